// File: doc/BRIEF.md
# Evenly Spread Programmable Rate Multiplier

This block thins a stream of input pulses down to a programmable fraction of its rate. Over each period of 2^N input pulses it lets exactly R of them through, where R is a rate value from 0 to 2^N. The passed pulses are spaced out across the period rather than bunched together. The output is still irregular: successive gaps take a small set of values, but the average ratio R/2^N holds exactly over every period.

A free-running N-bit counter advances on every enabled input cycle. Its bits are wired to a magnitude comparator in reversed order: the counter's least significant bit becomes the most significant bit of the compared value. An input passes when that reversed count is strictly below the current rate. The rate input is captured at reset and when the counter wraps. A change made partway through a period therefore only applies from the next period. A one-cycle wrap flag marks each period boundary. Both outputs are registered.

Top module: `rate_spreader`

## Requirements
- R1: While reset is high at a clock edge, the counter returns to zero, both outputs go low at that edge, and the rate input is captured.
- R2: Between two consecutive wrap flags, the number of passed pulses equals the rate captured for that period.
- R3: An enabled input seen when the counter holds c is passed exactly when the value of c with its N bits in reversed order (bit i moved to bit N-1-i) is strictly less than the captured rate.
- R4: A captured rate of 0 passes no pulse, and a captured rate of 2^N passes every enabled pulse.
- R5: The wrap output is high for one cycle, in the cycle after the enabled input that moves the counter from all ones to zero, and the counter then reads zero.
- R6: The rate input is captured only at reset and at that wrap transition. Changes at any other time have no effect on the current period.
- R7: A cycle without input enable leaves the counter unchanged and produces no pass and no wrap in the next cycle.
- R8: The outputs are registered: the pass and wrap decisions for an input appear one clock cycle after that input is presented.
- R9: For a captured rate R with 2^k <= R < 2^(k+1), no more than 2^(N-k) enabled inputs separate two passed pulses within one period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inEn | input | 1 | Input pulse, one per enabled cycle |
| rateIn | input | CNT_W+1 | Rate value R, 0 to 2^CNT_W |
| passOut | output | 1 | Registered passed pulse |
| wrapOut | output | 1 | Registered one-cycle period-boundary flag |

## Verification
The bench sweeps every rate from 0 to 2^N, one full period each. It predicts every single pass decision from the reversed count. A design that compared the count in natural order would show the expected count per period but fail the per-input pattern. A design with an inclusive compare would pass one pulse too many, and would pass a pulse at rate 0. During the first half of each period the rate input carries unrelated values, so a block that sampled the rate continuously would lose the exact count per period. Idle cycles are mixed into the stream, and a reset is applied mid-period. These expose a counter that advances without enable, and a wrap flag placed off the all-ones-to-zero step.

// File: rtl/rate_spreader_pkg.sv
package rate_spreader_pkg;

  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic clear;     // return counter and outputs to idle
    logic advance;   // an input pulse is present this cycle
    logic wrap;      // this advance moves the counter from all ones to zero
    logic loadRate;  // capture the rate input at this edge
  } strobe_t;

endpackage

// File: rtl/rs_control.sv
module rs_control
  import rate_spreader_pkg::*;
(
  input  logic    rst,
  input  logic    inEn,
  input  logic    atEnd,
  output strobe_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.clear    = rst;
    strobes.advance  = inEn && !rst;
    strobes.wrap     = inEn && !rst && atEnd;
    strobes.loadRate = rst || (inEn && atEnd);
  end

endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rate_spreader_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int RATE_W = CNT_W + 1
) (
  input  logic              clk,
  input  strobe_t           strobes,
  input  logic [RATE_W-1:0] rateIn,
  output logic              atEnd,
  output logic              passOut,
  output logic              wrapOut,
  output logic [CNT_W-1:0]  curCount,
  output logic [RATE_W-1:0] curRate
);

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  revCnt;
  logic [RATE_W-1:0] rateQ;
  logic              passQ;
  logic              wrapQ;
  logic              below;

  // Counter bit i drives comparator bit CNT_W-1-i.
  for (genvar i = 0; i < CNT_W; i++) begin : g_rev
    assign revCnt[i] = cntQ[CNT_W-1-i];
  end

  assign below = {1'b0, revCnt} < rateQ;
  assign atEnd = &cntQ;

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      cntQ <= '0;
    end else if (strobes.advance) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadRate) begin
      rateQ <= rateIn;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      passQ <= 1'b0;
      wrapQ <= 1'b0;
    end else begin
      passQ <= strobes.advance && below;
      wrapQ <= strobes.wrap;
    end
  end

  assign passOut  = passQ;
  assign wrapOut  = wrapQ;
  assign curCount = cntQ;
  assign curRate  = rateQ;

endmodule

// File: rtl/rate_spreader.sv
module rate_spreader
  import rate_spreader_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int RATE_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inEn,
  input  logic [RATE_W-1:0] rateIn,
  output logic              passOut,
  output logic              wrapOut
);

  strobe_t           strobes;
  logic              atEnd;
  logic [CNT_W-1:0]  curCount;
  logic [RATE_W-1:0] curRate;

  rs_control i_control (
    .rst     (rst),
    .inEn    (inEn),
    .atEnd   (atEnd),
    .strobes (strobes)
  );

  rs_datapath #(
    .CNT_W  (CNT_W),
    .RATE_W (RATE_W)
  ) i_datapath (
    .clk      (clk),
    .strobes  (strobes),
    .rateIn   (rateIn),
    .atEnd    (atEnd),
    .passOut  (passOut),
    .wrapOut  (wrapOut),
    .curCount (curCount),
    .curRate  (curRate)
  );

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int CNT_W  = 6,
  parameter int RATE_W = CNT_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              inEn,
  input logic              passOut,
  input logic              wrapOut,
  input logic [CNT_W-1:0]  curCount,
  input logic [RATE_W-1:0] curRate
);

  localparam logic [CNT_W-1:0]  LAST = '1;
  localparam logic [RATE_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!passOut && !wrapOut && curCount == '0));

  // R8
  pass_after_input_chk: assert property (@(posedge clk) disable iff (rst)
    passOut |-> $past(inEn));

  // R5
  wrap_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrapOut |-> (curCount == '0 && $past(inEn) && $past(curCount) == LAST));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inEn |=> ($stable(curCount) && !passOut && !wrapOut));

  // R4
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (inEn && curRate == '0) |=> !passOut);

  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (inEn && curRate == FULL) |=> passOut);

  // R6
  rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(inEn && curCount == LAST) |=> $stable(curRate));

endmodule

bind rate_spreader rs_checker #(
  .CNT_W  (CNT_W),
  .RATE_W (RATE_W)
) i_checker (
  .clk      (clk),
  .rst      (rst),
  .inEn     (inEn),
  .passOut  (passOut),
  .wrapOut  (wrapOut),
  .curCount (curCount),
  .curRate  (curRate)
);

// File: tb/test_rate_spreader.sv
module test_rate_spreader;

  localparam int CNT_W  = 6;
  localparam int RATE_W = CNT_W + 1;
  localparam int PERIOD = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inEn = 1'b0;
  logic [RATE_W-1:0] rateIn = '0;
  logic              passOut;
  logic              wrapOut;

  always #4 clk = ~clk;

  rate_spreader #(.CNT_W(CNT_W)) i_rate_spreader (
    .clk     (clk),
    .rst     (rst),
    .inEn    (inEn),
    .rateIn  (rateIn),
    .passOut (passOut),
    .wrapOut (wrapOut)
  );

  int checks = 0;
  int errors = 0;

  // Bench model state
  int mCnt = 0;
  int mRate = 0;
  bit expPass = 1'b0;
  bit expWrap = 1'b0;
  bit prevEn = 1'b0;
  int expPeriodRate = 0;
  int curPeriodRate = 0;
  int passCount = 0;
  int gap = 0;
  bit seenPass = 1'b0;

  function automatic int revBits(int v);
    int r = 0;
    for (int i = 0; i < CNT_W; i++) if (v[i]) r |= 1 << (CNT_W - 1 - i);
    return r;
  endfunction

  function automatic int gapBound(int r);
    int k = 0;
    while ((2 << k) <= r) k++;
    return PERIOD >> k;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One cycle: observe outputs for the previous input, then drive the next.
  task automatic step(bit en, int r);
    @(negedge clk);
    check(prevEn ? "R3 R8 pass decision" : "R7 idle cycle pass", int'(passOut), int'(expPass));
    check("R5 wrap flag", int'(wrapOut), int'(expWrap));
    if (prevEn) gap++;
    if (passOut) begin
      if (seenPass && curPeriodRate > 0) begin
        checks++;
        if (gap > gapBound(curPeriodRate)) begin
          errors++;
          $display("FAIL R9 spacing rate=%0d: actual=%0d expected<=%0d",
                   curPeriodRate, gap, gapBound(curPeriodRate));
        end
      end
      seenPass = 1'b1;
      gap = 0;
    end
    passCount += int'(passOut);
    if (wrapOut) begin
      if (expPeriodRate == 0 || expPeriodRate == PERIOD)
        check("R4 R2 extreme rate count", passCount, expPeriodRate);
      else
        check("R2 R6 count per period", passCount, expPeriodRate);
      passCount = 0;
      seenPass = 1'b0;
      gap = 0;
      curPeriodRate = mRate;
    end
    inEn = en;
    rateIn = RATE_W'(r);
    expPass = en && (revBits(mCnt) < mRate);
    expWrap = en && (mCnt == PERIOD - 1);
    if (en) begin
      if (mCnt == PERIOD - 1) begin
        expPeriodRate = mRate;
        mRate = r;
      end
      mCnt = (mCnt + 1) % PERIOD;
    end
    prevEn = en;
  endtask

  task automatic doReset(int r);
    @(negedge clk);
    rst = 1'b1;
    inEn = 1'b0;
    rateIn = RATE_W'(r);
    repeat (2) @(negedge clk);
    check("R1 pass low after reset", int'(passOut), 0);
    check("R1 wrap low after reset", int'(wrapOut), 0);
    rst = 1'b0;
    mCnt = 0;
    mRate = r;
    curPeriodRate = r;
    expPass = 1'b0;
    expWrap = 1'b0;
    prevEn = 1'b0;
    passCount = 0;
    gap = 0;
    seenPass = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    doReset(0);
    // Sweep every rate; the rate input carries junk for the first half
    // of each period, the next rate for the second half (R6).
    for (int p = 0; p <= PERIOD; p++) begin
      int nextRate = (p + 1 > PERIOD) ? PERIOD : p + 1;
      int junk = (p * 37 + 11) % (PERIOD + 1);
      for (int i = 0; i < PERIOD; i++) begin
        if ((p % 3 == 1) && (i % 5 == 2)) step(1'b0, junk);
        step(1'b1, (i < PERIOD / 2) ? junk : nextRate);
      end
    end
    for (int i = 0; i < 4; i++) step(1'b0, 3);

    // Mid-period reset: counter restarts at zero with the rate seen at reset (R1).
    for (int i = 0; i < 10; i++) step(1'b1, 9);
    doReset(5);
    for (int i = 0; i < 2 * PERIOD; i++) step(1'b1, 5);
    for (int i = 0; i < 3; i++) step(1'b0, 5);

    summary();
    $finish;
  end

endmodule